// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval counter. A 16-bit down-counter advances once per rising edge of `clk`. A `gate` input enables, triggers or retriggers it, depending on the mode, and a single output `out` carries the generated waveform. A host programs the channel over a byte-wide write port. One address takes a control byte that selects the counting mode and how count bytes are loaded. The other address takes the count bytes themselves.

Six modes are available:

| Code | Behaviour |
|---|---|
| 0 | Flag at terminal count |
| 1 | One-shot that the gate can retrigger |
| 2 | Rate generator with a one-clock low pulse per period |
| 3 | Square wave |
| 4 | Strobe started by software |
| 5 | Strobe started by a gate edge |

A count of zero stands for 65536. When the count is loaded as two bytes, writing the low byte freezes the counter. Writing the high byte restarts it with the new value.

Top module: `pit_channel`

## Requirements
- R1: After reset `out` is 1 and the counter is idle. Count writes made before the first accepted control byte are ignored and leave `out` at 1.
- R2: Control byte fields are: mode code in bits [2:0], and load style in bits [4:3] (01 low byte only, 10 high byte only, 11 low then high). A control byte with mode code 6 or 7, or with load style 00, is ignored, and a running count carries on unchanged. An accepted control byte stops the counter, drives `out` low in mode 0 and high in every other mode, and clears any armed count.
- R3: A single-byte load clears the other byte. A count of 0 means 65536. In modes 0, 2, 3 and 4 the counter takes the new value on the clock after the write that completes the count.
- R4: In low-then-high loading, the low-byte write freezes the counter and `out`. The high-byte write completes the count and restarts counting from the new value.
- R5: Mode 0 with count N: `out` stays low from the control write, then rises N+1 clocks after the completing count write and stays high.
- R6: Mode 1 with count N: a rising gate edge after a count has been written drives `out` low for N clocks. A further rising edge during the pulse reloads N and extends the pulse. A rising edge before any count has been written has no effect.
- R7: Mode 2 with count N: `out` is low for one clock every N clocks. The first low clock comes N clocks after the completing write.
- R8: Mode 3 with count N: `out` is high for ceil(N/2) clocks and low for floor(N/2) clocks, repeating. The first high phase includes the load clock.
- R9: Mode 4 with count N: `out` stays high for N+1 clocks after the completing write, then goes low for exactly one clock and returns high for good.
- R10: Mode 5 with count N: a rising gate edge starts the count. `out` goes low for one clock N clocks after that edge, and a new edge reloads the count.
- R11: In modes 2 and 3 a count of 1 acts as a count of 2.
- R12: In modes 0, 2, 3 and 4, counting pauses on every clock at which `gate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one counting step |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | Count enable (modes 0, 2, 3, 4) or trigger (modes 1, 5) |
| wr_en | input | 1 | Host write strobe, one clock per byte |
| wr_ctl | input | 1 | 1 selects the control byte, 0 selects the count byte |
| wr_data | input | BYTE_W | Written byte |
| out | output | 1 | Channel output waveform |

## Verification
The hardest situation to reach is a half-written two-byte count that lands in the middle of a running count. The bench starts a mode 0 count and lets it run for a few clocks. It then writes only a new low byte and waits past the clock at which the old count would have expired, confirming that `out` never rose. Only after that does it supply the high byte and time the fresh count. The one-shot retrigger is reached the same way: the gate is dropped and raised again inside a running pulse, and the measured low time must exceed the programmed count.

// File: rtl/pit_pkg.sv
package pit_pkg;

   // Counting modes; the codes are the values of the control byte mode field.
   typedef enum logic [2:0] {
      PM_TERM    = 3'd0,
      PM_ONESHOT = 3'd1,
      PM_RATE    = 3'd2,
      PM_SQUARE  = 3'd3,
      PM_SWSTB   = 3'd4,
      PM_HWSTB   = 3'd5
   } pit_mode_e;

   // Count loading styles; the codes are the values of the control byte load field.
   typedef enum logic [1:0] {
      PA_NONE = 2'd0,
      PA_LO   = 2'd1,
      PA_HI   = 2'd2,
      PA_LOHI = 2'd3
   } pit_acc_e;

   localparam int MODE_LSB = 0;
   localparam int MODE_W   = 3;
   localparam int ACC_LSB  = 3;
   localparam int ACC_W    = 2;
   localparam int MODE_MAX = 5;

   // Modes in which a low gate level pauses counting.
   function automatic logic mode_is_gated(pit_mode_e m);
      return (m == PM_TERM) || (m == PM_RATE) || (m == PM_SQUARE) || (m == PM_SWSTB);
   endfunction

endpackage

// File: rtl/pit_hostif.sv
module pit_hostif
   import pit_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_ctl,
   input  logic [BYTE_W-1:0]     wr_data,
   output pit_mode_e             mode_o,
   output logic                  ctl_we_o,
   output pit_mode_e             ctl_mode_o,
   output logic [2*BYTE_W-1:0]   reload_o,
   output logic                  cnt_done_o,
   output logic                  lsb_hold_o
);

   localparam int NLANE = 2;

   logic [MODE_W-1:0] f_mode;
   logic [ACC_W-1:0]  f_acc;
   logic              ctl_ok;
   logic              cnt_we;
   pit_mode_e         mode_q;
   pit_acc_e          acc_q;
   logic              hi_next_q;
   logic [NLANE-1:0]  lane_hit;
   logic [NLANE-1:0]  lane_clr;
   logic [BYTE_W-1:0] lane_q [NLANE];

   assign f_mode     = wr_data[MODE_LSB +: MODE_W];
   assign f_acc      = wr_data[ACC_LSB +: ACC_W];
   assign ctl_ok     = (f_mode <= MODE_W'(MODE_MAX)) && (f_acc != '0);
   assign ctl_we_o   = wr_en & wr_ctl & ctl_ok;
   assign ctl_mode_o = pit_mode_e'(f_mode);
   assign cnt_we     = wr_en & ~wr_ctl;
   assign mode_o     = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= PM_TERM;
         acc_q     <= PA_NONE;
         hi_next_q <= 1'b0;
      end else if (ctl_we_o) begin
         mode_q    <= ctl_mode_o;
         acc_q     <= pit_acc_e'(f_acc);
         hi_next_q <= 1'b0;
      end else if (cnt_we && acc_q == PA_LOHI) begin
         hi_next_q <= ~hi_next_q;
      end
   end

   assign lane_hit[0] = cnt_we & ((acc_q == PA_LO) | ((acc_q == PA_LOHI) & ~hi_next_q));
   assign lane_hit[1] = cnt_we & ((acc_q == PA_HI) | ((acc_q == PA_LOHI) &  hi_next_q));
   assign lane_clr[0] = cnt_we & (acc_q == PA_HI);
   assign lane_clr[1] = cnt_we & (acc_q == PA_LO);

   generate
      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           lane_q[g] <= '0;
            else if (lane_hit[g]) lane_q[g] <= wr_data;
            else if (lane_clr[g]) lane_q[g] <= '0;
         end
         assign reload_o[g*BYTE_W +: BYTE_W] = lane_q[g];
      end
   endgenerate

   assign cnt_done_o = cnt_we & ((acc_q == PA_LO) | (acc_q == PA_HI) |
                                 ((acc_q == PA_LOHI) & hi_next_q));
   assign lsb_hold_o = cnt_we & (acc_q == PA_LOHI) & ~hi_next_q;

   // R2: a rejected control byte leaves the stored configuration untouched
   a_r2_bad_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ctl && !ctl_ok) |=> ($stable(mode_q) && $stable(acc_q)));

   // R1: without an accepted control byte no count write completes
   a_r1_no_count_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q == PA_NONE) |-> !(cnt_done_o || lsb_hold_o));

endmodule

// File: rtl/pit_core.sv
module pit_core
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  pit_mode_e        mode,
   input  logic             ctl_we,
   input  pit_mode_e        ctl_mode,
   input  logic [CNT_W-1:0] reload,
   input  logic             cnt_done,
   input  logic             lsb_hold,
   output logic             out_o
);

   localparam int VW = CNT_W + 1;
   localparam logic [VW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

   logic [VW-1:0] span, eff, hi_len, lo_len, cnt_q;
   logic out_q, run_q, armed_q, pend_q, halt_q, stb_q, gate_q;
   logic gated, wrap, rise, fire, tick, last;

   assign span   = (reload == '0) ? FULL : {1'b0, reload};
   assign wrap   = (mode == PM_RATE) || (mode == PM_SQUARE);
   assign eff    = (wrap && span == VW'(1)) ? VW'(2) : span;
   assign hi_len = (eff + VW'(1)) >> 1;
   assign lo_len = eff >> 1;
   assign gated  = mode_is_gated(mode);
   assign rise   = gate & ~gate_q;
   assign fire   = ~gated & armed_q & rise & ~halt_q;
   assign tick   = run_q & ~halt_q & ~lsb_hold & (~gated | gate);
   assign last   = (cnt_q == VW'(1));
   assign out_o  = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         out_q   <= 1'b1;
         run_q   <= 1'b0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         halt_q  <= 1'b0;
         stb_q   <= 1'b0;
         gate_q  <= 1'b0;
      end else begin
         gate_q <= gate;
         stb_q  <= 1'b0;
         if (stb_q) out_q <= 1'b1;
         if (ctl_we) begin
            out_q   <= (ctl_mode != PM_TERM);
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            halt_q  <= 1'b0;
         end else begin
            if (pend_q) begin
               cnt_q  <= (mode == PM_SQUARE) ? hi_len : eff;
               run_q  <= 1'b1;
               pend_q <= 1'b0;
               if (mode != PM_TERM) out_q <= 1'b1;
            end else if (fire) begin
               cnt_q <= eff;
               run_q <= 1'b1;
               out_q <= (mode != PM_ONESHOT);
            end else if (tick) begin
               case (mode)
                  PM_RATE: begin
                     if (cnt_q == VW'(2)) begin
                        cnt_q <= VW'(1);
                        out_q <= 1'b0;
                     end else if (last) begin
                        cnt_q <= eff;
                        out_q <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q - VW'(1);
                     end
                  end
                  PM_SQUARE: begin
                     if (last) begin
                        out_q <= ~out_q;
                        cnt_q <= out_q ? lo_len : hi_len;
                     end else begin
                        cnt_q <= cnt_q - VW'(1);
                     end
                  end
                  default: begin
                     if (last) begin
                        cnt_q <= '0;
                        run_q <= 1'b0;
                        if (mode == PM_SWSTB || mode == PM_HWSTB) begin
                           out_q <= 1'b0;
                           stb_q <= 1'b1;
                        end else begin
                           out_q <= 1'b1;
                        end
                     end else begin
                        cnt_q <= cnt_q - VW'(1);
                     end
                  end
               endcase
            end
            if (lsb_hold) halt_q <= 1'b1;
            if (cnt_done) begin
               halt_q  <= 1'b0;
               armed_q <= 1'b1;
               if (gated) pend_q <= 1'b1;
               if (mode == PM_TERM) out_q <= 1'b0;
            end
         end
      end
   end

   // R3: a running counter never holds zero (zero is only the idle value)
   a_r3_live_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0));

   // R12: a low gate in a gated mode freezes the count
   a_r12_gate_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && gated && !gate && !ctl_we && !pend_q) |=> $stable(cnt_q));

   // R4: while a two-byte load is half written the count does not move
   a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !ctl_we && !pend_q) |=> $stable(cnt_q));

   // R9 and R10: a strobe is low for exactly one clock
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(out_q) && (mode == PM_SWSTB || mode == PM_HWSTB) && !ctl_we) |=> out_q);

   // R7: the rate pulse lasts one counting clock
   a_r7_rate_low_one: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_RATE && run_q && !out_q && gate && !halt_q && !lsb_hold && !ctl_we)
      |=> out_q);

   // R5: in mode 0 the output is low for as long as the count runs
   a_r5_term_low_while_running: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_TERM && run_q) |-> !out_q);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit GATE_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate,
   input  logic              wr_en,
   input  logic              wr_ctl,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              out
);

   localparam int CNT_W = 2 * BYTE_W;

   initial begin
      assert (BYTE_W >= ACC_LSB + ACC_W)
         else $error("pit_channel: BYTE_W too narrow for the control fields");
   end

   logic              gate_c;
   pit_mode_e         mode;
   pit_mode_e         ctl_mode;
   logic              ctl_we;
   logic [CNT_W-1:0]  reload;
   logic              cnt_done;
   logic              lsb_hold;

   generate
      if (GATE_SYNC) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], gate};
         end
         assign gate_c = sync_q[1];
      end else begin : g_direct
         assign gate_c = gate;
      end
   endgenerate

   pit_hostif #(.BYTE_W(BYTE_W)) u_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_ctl     (wr_ctl),
      .wr_data    (wr_data),
      .mode_o     (mode),
      .ctl_we_o   (ctl_we),
      .ctl_mode_o (ctl_mode),
      .reload_o   (reload),
      .cnt_done_o (cnt_done),
      .lsb_hold_o (lsb_hold)
   );

   pit_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (gate_c),
      .mode     (mode),
      .ctl_we   (ctl_we),
      .ctl_mode (ctl_mode),
      .reload   (reload),
      .cnt_done (cnt_done),
      .lsb_hold (lsb_hold),
      .out_o    (out)
   );

endmodule

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gate = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_ctl = 1'b0;
   logic [7:0] wr_data = '0;
   logic       out;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   bit done = 1'b0;

   pit_channel dut (
      .clk(clk), .rst_n(rst_n), .gate(gate), .wr_en(wr_en),
      .wr_ctl(wr_ctl), .wr_data(wr_data), .out(out)
   );

   always #5 clk = ~clk;

   typedef struct packed {
      logic [2:0]  mode;
      logic [1:0]  acc;
      logic [15:0] cnt;
      logic [31:0] ea;
      logic [31:0] eb;
      logic [31:0] ec;
   } vec_t;

   // Run lengths of out, sampled once per clock starting after the last write
   // (or after the trigger edge in modes 1 and 5). 0 means the run is not checked.
   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 2'd1, 16'd5,      32'd6,     32'd0, 32'd0},  // R5
      '{3'd0, 2'd2, 16'h0100,   32'd257,   32'd0, 32'd0},  // R3 high byte only
      '{3'd0, 2'd3, 16'd3,      32'd4,     32'd0, 32'd0},  // R3 two bytes
      '{3'd1, 2'd1, 16'd4,      32'd4,     32'd0, 32'd0},  // R6
      '{3'd2, 2'd1, 16'd4,      32'd4,     32'd1, 32'd3},  // R7
      '{3'd2, 2'd1, 16'd2,      32'd2,     32'd1, 32'd1},  // R7 minimum
      '{3'd2, 2'd1, 16'd1,      32'd2,     32'd1, 32'd1},  // R11
      '{3'd3, 2'd1, 16'd5,      32'd4,     32'd2, 32'd3},  // R8 odd
      '{3'd3, 2'd1, 16'd6,      32'd4,     32'd3, 32'd3},  // R8 even
      '{3'd3, 2'd1, 16'd1,      32'd2,     32'd1, 32'd1},  // R11
      '{3'd3, 2'd1, 16'd3,      32'd3,     32'd1, 32'd2},  // R8
      '{3'd4, 2'd1, 16'd3,      32'd4,     32'd1, 32'd0},  // R9
      '{3'd5, 2'd1, 16'd3,      32'd3,     32'd1, 32'd0},  // R10
      '{3'd0, 2'd3, 16'd0,      32'd65537, 32'd0, 32'd0}   // R3 zero is 65536
   };

   function automatic string mode_tag(logic [2:0] m, logic [15:0] c);
      if ((m == 3'd2 || m == 3'd3) && c == 16'd1) return "R11";
      if (c == 16'd0 || c == 16'h0100 || c == 16'd3 && m == 3'd0) return "R3";
      case (m)
         3'd0: return "R5";
         3'd1: return "R6";
         3'd2: return "R7";
         3'd3: return "R8";
         3'd4: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic ctl, input logic [7:0] d);
      wr_en = 1'b1; wr_ctl = ctl; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_ctl = 1'b0;
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (out === lvl && n < 70000) begin
         n++;
         @(negedge clk);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected under 190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset out", int'(out), 1);
      // R1: count write before any control byte is dropped
      gate = 1'b1;
      wr(1'b0, 8'h05);
      repeat (5) @(negedge clk);
      chk("R1 unconfigured count", int'(out), 1);

      for (int i = 0; i < NV; i++) begin
         automatic vec_t v = VEC[i];
         automatic logic trig = (v.mode == 3'd1) || (v.mode == 3'd5);
         automatic logic lvl = (v.mode >= 3'd2);
         automatic string tg = mode_tag(v.mode, v.cnt);
         gate = ~trig;
         wr(1'b1, {3'b000, v.acc, v.mode});
         if (v.acc != 2'd2) wr(1'b0, v.cnt[7:0]);
         if (v.acc != 2'd1) wr(1'b0, v.cnt[15:8]);
         if (trig) begin
            gate = 1'b1;
            @(negedge clk);
         end
         run_len(lvl, n);
         chk({tg, " first run"}, n, int'(v.ea));
         if (v.eb != 0) begin
            run_len(~lvl, n);
            chk({tg, " second run"}, n, int'(v.eb));
         end
         if (v.ec != 0) begin
            run_len(lvl, n);
            chk({tg, " third run"}, n, int'(v.ec));
         end
      end

      // R12: gate low for three clocks (one of them the load clock) in mode 0
      gate = 1'b1;
      wr(1'b1, 8'h08);
      wr(1'b0, 8'd5);
      gate = 1'b0;
      repeat (3) @(negedge clk);
      gate = 1'b1;
      chk("R12 out low while paused", int'(out), 0);
      run_len(1'b0, n);
      chk("R12 remaining low run", n, 5);

      // R4: low byte alone freezes a running count; high byte restarts it
      wr(1'b1, 8'h18);
      wr(1'b0, 8'd6);
      wr(1'b0, 8'd0);
      repeat (2) @(negedge clk);
      wr(1'b0, 8'd3);
      repeat (8) @(negedge clk);
      chk("R4 frozen out stays low", int'(out), 0);
      wr(1'b0, 8'd0);
      run_len(1'b0, n);
      chk("R4 restarted low run", n, 4);

      // R6: gate edge before any count is ignored, then retrigger extends
      gate = 1'b0;
      wr(1'b1, 8'h09);
      gate = 1'b1;
      repeat (4) @(negedge clk);
      chk("R6 edge without count", int'(out), 1);
      wr(1'b0, 8'd4);
      gate = 1'b0;
      @(negedge clk);
      gate = 1'b1;
      @(negedge clk);
      chk("R6 pulse started", int'(out), 0);
      @(negedge clk);
      gate = 1'b0;
      @(negedge clk);
      gate = 1'b1;
      @(negedge clk);
      run_len(1'b0, n);
      chk("R6 retriggered low run", n, 4);

      // R2: load style 00 and mode code 7 are both rejected
      gate = 1'b1;
      wr(1'b1, 8'h08);
      wr(1'b0, 8'd5);
      wr(1'b1, 8'h04);
      wr(1'b1, 8'h0F);
      run_len(1'b0, n);
      chk("R2 count unaffected", n, 4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule